// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel Pair

This block moves data between one serial peripheral and system memory with no processor work per item. It holds a transmit direction and a receive direction. Each direction keeps an active buffer (a memory pointer and an item count) and a queued buffer of the same shape. When the active count runs out and a queued buffer is waiting, the queued pair is moved into the active pair on the same clock edge, so back-to-back buffers stream with no idle cycle between them.

The peripheral asks for one item per cycle by raising its transmit or receive request. A transmit grant issues a single-beat memory read at the active transmit pointer. The read data comes back one cycle later and is handed to the peripheral with a one-cycle valid strobe. A receive grant issues a single-beat memory write of the peripheral's data at the active receive pointer. Software programs both buffer pairs and the direction enables through a small register port. It watches completion through level flags and a status word.

Top module: `pdma_pair`

## Requirements
- R1: After reset, all pointers and counts read zero and both directions are disabled. Status reads 0x3C, the four flag outputs are high, and no memory access or transmit strobe is issued.
- R2: Register offsets: transmit active pointer 0, active count 1, queued pointer 2, queued count 3. The receive direction uses 4 to 7 in the same order. Control is at 8 and reads zero. Status is at 9. Reads are combinational on `reg_addr`. Counts are zero-extended.
- R3: A control write sets the transmit enable with bit 0 and clears it with bit 1. Bits 2 and 3 do the same for receive. When set and clear are written together, clear wins. Status bit 0 is the transmit enable and bit 1 is the receive enable.
- R4: A transmit request is granted when the transmit direction is enabled and its active count is nonzero. The grant raises `mem_rd_en` in that cycle, with `mem_rd_addr` equal to the active pointer. The pointer then advances by ITEM_BYTES and the count drops by one.
- R5: The cycle after a transmit grant, `tx_valid` is high for exactly one cycle and `tx_data` equals the memory read data of that cycle.
- R6: A receive request is granted under the same rule as R4. The grant raises `mem_wr_en` in that cycle, with `mem_wr_addr` equal to the active receive pointer and `mem_wr_data` equal to `rx_data`. The pointer and count then update as in R4.
- R7: A request made while its direction is disabled, or while its active count is zero, makes no memory access and changes no register. Writing a nonzero active count while the direction is enabled rearms transfers.
- R8: When the count after the current cycle's grant would be zero and the queued count is nonzero, the queued pointer and count replace the active pair on that edge and the queued count becomes zero. This also happens when the active count is already zero.
- R9: The end flag of a direction is high while its active count is zero. `tx_empty` and `rx_full` are high while both the active and queued counts of their direction are zero. Status bits 2, 3, 4 and 5 are tx end, tx empty, rx end and rx full.
- R10: A register write to a pointer or count takes priority over the grant or reload update of that same field on the same edge. Other fields still update.
- R11: Writing zero to the receive active count, while the queued receive count is zero, stops all further receive writes. The receive pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_req | input | 1 | Peripheral asks for one transmit item |
| tx_valid | output | 1 | Transmit item valid strobe |
| tx_data | output | DW | Transmit item |
| rx_req | input | 1 | Peripheral offers one receive item |
| rx_data | input | DW | Receive item |
| mem_rd_en | output | 1 | Single-beat memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Single-beat memory write request |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| tx_end | output | 1 | Transmit active count is zero |
| tx_empty | output | 1 | Both transmit counts are zero |
| rx_end | output | 1 | Receive active count is zero |
| rx_full | output | 1 | Both receive counts are zero |

## Verification
A corrupted pointer shows on the very next granted access as a wrong memory address, and on the register read port in any cycle that reads it. A wrong count or a missed reload shows as an extra or missing memory strobe, or as an end or empty flag that toggles one cycle early or late. The bench mirrors every register with a behavioural model and compares all outputs each clock, so a divergence is reported in the cycle it first reaches a port. The comparison also cycles through every register offset.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    OFS_CTRL = 4'd8,
    OFS_STAT = 4'd9
  } ofs_e;

  // per-direction field write strobes
  typedef struct packed {
    logic act_ptr;
    logic act_cnt;
    logic que_ptr;
    logic que_cnt;
  } fld_wr_t;
endpackage

// File: rtl/pdma_dir.sv
module pdma_dir
  import pdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int ITEM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              en,
  input  fld_wr_t           fwr,
  input  logic [REG_DW-1:0] wdata,
  output logic              go,
  output logic [AW-1:0]     act_ptr_q,
  output logic [CW-1:0]     act_cnt_q,
  output logic [AW-1:0]     que_ptr_q,
  output logic [CW-1:0]     que_cnt_q
);
  localparam logic [AW-1:0] STEP = AW'(ITEM_BYTES);

  logic [AW-1:0] act_ptr_d, que_ptr_d, ptr_step;
  logic [CW-1:0] act_cnt_d, que_cnt_d, cnt_step;

  always_comb begin
    go        = req && en && (act_cnt_q != '0);
    ptr_step  = act_ptr_q + (go ? STEP : '0);
    cnt_step  = act_cnt_q - CW'(go);
    que_ptr_d = que_ptr_q;
    if ((cnt_step == '0) && (que_cnt_q != '0)) begin
      act_ptr_d = que_ptr_q;
      act_cnt_d = que_cnt_q;
      que_cnt_d = '0;
    end else begin
      act_ptr_d = ptr_step;
      act_cnt_d = cnt_step;
      que_cnt_d = que_cnt_q;
    end
    if (fwr.act_ptr) act_ptr_d = wdata[AW-1:0];
    if (fwr.act_cnt) act_cnt_d = wdata[CW-1:0];
    if (fwr.que_ptr) que_ptr_d = wdata[AW-1:0];
    if (fwr.que_cnt) que_cnt_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ptr_q <= '0;
      act_cnt_q <= '0;
      que_ptr_q <= '0;
      que_cnt_q <= '0;
    end else begin
      act_ptr_q <= act_ptr_d;
      act_cnt_q <= act_cnt_d;
      que_ptr_q <= que_ptr_d;
      que_cnt_q <= que_cnt_d;
    end
  end

  // R4: a grant with no register write steps count and pointer
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && act_cnt_q > CW'(1) && fwr == '0) |=> act_cnt_q == $past(act_cnt_q) - CW'(1));
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && act_cnt_q > CW'(1) && fwr == '0) |=> act_ptr_q == $past(act_ptr_q) + STEP);
  // R7: no grant and no write leaves the active pair alone
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && act_cnt_q != '0 && fwr == '0) |=> $stable(act_cnt_q) && $stable(act_ptr_q));
  // R8: idle reload and last-item reload
  p_idle_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cnt_q == '0 && que_cnt_q != '0 && fwr == '0)
      |=> act_cnt_q == $past(que_cnt_q) && que_cnt_q == '0);
  p_last_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && act_cnt_q == CW'(1) && que_cnt_q != '0 && fwr == '0)
      |=> act_ptr_q == $past(que_ptr_q) && act_cnt_q == $past(que_cnt_q));
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [2*NDIR-1:0]          ctl_bits,
  input  logic [NDIR-1:0][AW-1:0]    act_ptr,
  input  logic [NDIR-1:0][CW-1:0]    act_cnt,
  input  logic [NDIR-1:0][AW-1:0]    que_ptr,
  input  logic [NDIR-1:0][CW-1:0]    que_cnt,
  input  logic [NDIR-1:0]            end_flg,
  input  logic [NDIR-1:0]            none_flg,
  output fld_wr_t [NDIR-1:0]         fwr,
  output logic [NDIR-1:0]            en_q,
  output logic [REG_DW-1:0]          reg_rdata
);
  logic            ctl_wr;
  logic [NDIR-1:0] en_d;

  always_comb begin
    ctl_wr = reg_wr && (reg_addr == OFS_CTRL);
    for (int d = 0; d < NDIR; d++) begin
      fwr[d].act_ptr = reg_wr && (reg_addr == REG_AW'(4*d + 0));
      fwr[d].act_cnt = reg_wr && (reg_addr == REG_AW'(4*d + 1));
      fwr[d].que_ptr = reg_wr && (reg_addr == REG_AW'(4*d + 2));
      fwr[d].que_cnt = reg_wr && (reg_addr == REG_AW'(4*d + 3));
      en_d[d] = ctl_wr ? ((en_q[d] | ctl_bits[2*d]) & ~ctl_bits[2*d+1]) : en_q[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < REG_AW'(4*NDIR)) begin
      case (reg_addr[1:0])
        2'd0:    reg_rdata = REG_DW'(act_ptr[reg_addr[2]]);
        2'd1:    reg_rdata = REG_DW'(act_cnt[reg_addr[2]]);
        2'd2:    reg_rdata = REG_DW'(que_ptr[reg_addr[2]]);
        default: reg_rdata = REG_DW'(que_cnt[reg_addr[2]]);
      endcase
    end else if (reg_addr == OFS_STAT) begin
      reg_rdata = REG_DW'({none_flg[DIR_RX], end_flg[DIR_RX],
                           none_flg[DIR_TX], end_flg[DIR_TX], en_q});
    end
  end

  // R3: clear bit wins over set bit
  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[1]) |=> !en_q[DIR_TX]);
  p_set_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[2] && !ctl_bits[3]) |=> en_q[DIR_RX]);
endmodule

// File: rtl/pdma_pair.sv
module pdma_pair
  import pdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int DW         = 32,
  parameter int ITEM_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          tx_req,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          rx_req,
  input  logic [DW-1:0] rx_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          tx_end,
  output logic          tx_empty,
  output logic          rx_end,
  output logic          rx_full
);
  logic [NDIR-1:0]         req, en, go, end_flg, none_flg;
  fld_wr_t [NDIR-1:0]      fwr;
  logic [NDIR-1:0][AW-1:0] act_ptr, que_ptr;
  logic [NDIR-1:0][CW-1:0] act_cnt, que_cnt;
  logic                    tx_valid_d, tx_valid_q;

  assign req[DIR_TX] = tx_req;
  assign req[DIR_RX] = rx_req;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    pdma_dir #(.AW(AW), .CW(CW), .ITEM_BYTES(ITEM_BYTES)) u_dir (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[d]),
      .en        (en[d]),
      .fwr       (fwr[d]),
      .wdata     (reg_wdata),
      .go        (go[d]),
      .act_ptr_q (act_ptr[d]),
      .act_cnt_q (act_cnt[d]),
      .que_ptr_q (que_ptr[d]),
      .que_cnt_q (que_cnt[d])
    );
    assign end_flg[d]  = (act_cnt[d] == '0);
    assign none_flg[d] = end_flg[d] && (que_cnt[d] == '0);
  end

  pdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .ctl_bits  (reg_wdata[2*NDIR-1:0]),
    .act_ptr   (act_ptr),
    .act_cnt   (act_cnt),
    .que_ptr   (que_ptr),
    .que_cnt   (que_cnt),
    .end_flg   (end_flg),
    .none_flg  (none_flg),
    .fwr       (fwr),
    .en_q      (en),
    .reg_rdata (reg_rdata)
  );

  always_comb tx_valid_d = go[DIR_TX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid_q <= 1'b0;
    else        tx_valid_q <= tx_valid_d;
  end

  assign tx_valid    = tx_valid_q;
  assign tx_data     = mem_rd_data;
  assign mem_rd_en   = go[DIR_TX];
  assign mem_rd_addr = act_ptr[DIR_TX];
  assign mem_wr_en   = go[DIR_RX];
  assign mem_wr_addr = act_ptr[DIR_RX];
  assign mem_wr_data = rx_data;
  assign tx_end      = end_flg[DIR_TX];
  assign tx_empty    = none_flg[DIR_TX];
  assign rx_end      = end_flg[DIR_RX];
  assign rx_full     = none_flg[DIR_RX];

  // R5: one valid strobe follows each read, none otherwise
  p_strobe_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> tx_valid);
  p_no_stray_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> !tx_valid);
  // R9: an empty direction is also at its end
  p_empty_implies_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty |-> tx_end) and (rx_full |-> rx_end));
endmodule

// File: tb/pdma_pair_tb_top.sv
module pdma_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_req, tx_valid, rx_req;
  logic [31:0] tx_data, rx_data;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic        tx_end, tx_empty, rx_end, rx_full;

  always #10 clk = ~clk;

  pdma_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_req(rx_req), .rx_data(rx_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .tx_end(tx_end), .tx_empty(tx_empty), .rx_end(rx_end), .rx_full(rx_full)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  int unsigned m_ptr [2], m_cnt [2], m_nptr [2], m_ncnt [2];
  bit          m_en  [2];
  bit          exp_txv;
  int unsigned exp_txd;
  // one extra directed check in the next cycle
  bit          d_on;
  string       d_tag;
  int unsigned d_exp;

  function automatic int unsigned mem_fn(int unsigned a);
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned m_read(int a);
    if (a < 8) begin
      case (a % 4)
        0: return m_ptr[a/4];
        1: return m_cnt[a/4];
        2: return m_nptr[a/4];
        default: return m_ncnt[a/4];
      endcase
    end
    if (a == 9)
      return {26'd0, (m_cnt[1] == 0 && m_ncnt[1] == 0), (m_cnt[1] == 0),
              (m_cnt[0] == 0 && m_ncnt[0] == 0), (m_cnt[0] == 0), m_en[1], m_en[0]};
    return 0;
  endfunction

  task automatic compare_all();
    bit g0, g1;
    g0 = tx_req && m_en[0] && m_cnt[0] != 0;
    g1 = rx_req && m_en[1] && m_cnt[1] != 0;
    chk(g0 ? "R4" : "R7", "mem_rd_en", mem_rd_en, g0);
    if (g0) chk("R4", "mem_rd_addr", mem_rd_addr, m_ptr[0]);
    chk(g1 ? "R6" : "R7", "mem_wr_en", mem_wr_en, g1);
    if (g1) begin
      chk("R6", "mem_wr_addr", mem_wr_addr, m_ptr[1]);
      chk("R6", "mem_wr_data", mem_wr_data, rx_data);
    end
    chk("R5", "tx_valid", tx_valid, exp_txv);
    if (exp_txv) chk("R5", "tx_data", tx_data, exp_txd);
    chk("R9", "tx_end",   tx_end,   m_cnt[0] == 0);
    chk("R9", "tx_empty", tx_empty, m_cnt[0] == 0 && m_ncnt[0] == 0);
    chk("R9", "rx_end",   rx_end,   m_cnt[1] == 0);
    chk("R9", "rx_full",  rx_full,  m_cnt[1] == 0 && m_ncnt[1] == 0);
    chk("R2", "reg_rdata", reg_rdata, m_read(int'(reg_addr)));
    if (d_on) begin
      chk(d_tag, "directed read", reg_rdata, d_exp);
      d_on = 0;
    end
  endtask

  task automatic model_update();
    bit g [2];
    int unsigned ca, pa;
    g[0] = tx_req && m_en[0] && m_cnt[0] != 0;
    g[1] = rx_req && m_en[1] && m_cnt[1] != 0;
    exp_txv = g[0];
    exp_txd = mem_fn(m_ptr[0]);
    for (int d = 0; d < 2; d++) begin
      ca = m_cnt[d] - (g[d] ? 1 : 0);
      pa = m_ptr[d] + (g[d] ? 4 : 0);
      if (ca == 0 && m_ncnt[d] != 0) begin
        m_ptr[d] = m_nptr[d]; m_cnt[d] = m_ncnt[d]; m_ncnt[d] = 0;
      end else begin
        m_ptr[d] = pa; m_cnt[d] = ca;
      end
    end
    if (reg_wr) begin
      if (reg_addr < 8) begin
        case (reg_addr % 4)
          0: m_ptr[reg_addr/4]  = reg_wdata;
          1: m_cnt[reg_addr/4]  = reg_wdata & 32'hFFFF;
          2: m_nptr[reg_addr/4] = reg_wdata;
          default: m_ncnt[reg_addr/4] = reg_wdata & 32'hFFFF;
        endcase
      end else if (reg_addr == 8) begin
        for (int d = 0; d < 2; d++)
          m_en[d] = (m_en[d] | reg_wdata[2*d]) & ~reg_wdata[2*d+1];
      end
    end
  endtask

  task automatic cyc();
    bit          pend;
    int unsigned pa;
    #8;
    compare_all();
    pend = mem_rd_en;
    pa   = mem_rd_addr;
    @(posedge clk);
    if (rst_n) model_update();
    mem_rd_data = pend ? mem_fn(pa) : 32'hDEAD_0000;
    @(negedge clk);
  endtask

  task automatic wr(int a, int unsigned v);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = v;
    cyc();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(int a, int unsigned v, string tag);
    reg_addr = 4'(a); d_on = 1; d_exp = v; d_tag = tag;
    cyc();
  endtask

  task automatic reqs(bit t, bit r, int n);
    for (int i = 0; i < n; i++) begin
      tx_req = t; rx_req = r && (i % 2 == 0); rx_data = 32'h0BAD_0000 + i;
      reg_addr = 4'(i % 10);
      cyc();
    end
    tx_req = 0; rx_req = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    tx_req = 0; rx_req = 0; rx_data = 0; mem_rd_data = 0; d_on = 0;
    for (int d = 0; d < 2; d++) begin
      m_ptr[d] = 0; m_cnt[d] = 0; m_nptr[d] = 0; m_ncnt[d] = 0; m_en[d] = 0;
    end
    exp_txv = 0; exp_txd = 0;
    @(negedge clk);
    rd(9, 32'h3C, "R1");
    rd(0, 0, "R1");
    @(negedge clk);
    rst_n = 1;
    rd(9, 32'h3C, "R1");
    rd(5, 0, "R1");

    // program transmit, requests while disabled
    wr(0, 32'h1000); wr(1, 3); wr(2, 32'h2000); wr(3, 2);
    reqs(1, 0, 3);
    rd(1, 3, "R7");
    rd(0, 32'h1000, "R7");

    // enable transmit; two buffers chain, then requests ignored
    wr(8, 1);
    reqs(1, 0, 7);
    rd(0, 32'h2008, "R8");
    rd(3, 0, "R8");
    rd(2, 32'h2000, "R8");
    rd(9, 32'h3D, "R9");

    // receive with chaining, alternating requests
    wr(4, 32'h4000); wr(5, 4); wr(6, 32'h5000); wr(7, 1); wr(8, 4);
    reqs(0, 1, 10);
    rd(4, 32'h5004, "R6");
    rd(5, 0, "R6");

    // rearm transmit by writing a nonzero count
    wr(1, 2);
    reqs(1, 0, 3);
    rd(0, 32'h2010, "R7");

    // register write wins over the grant update of the same field
    wr(1, 5);
    tx_req = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 9;
    cyc();
    tx_req = 0; reg_wr = 0; reg_wdata = 0;
    rd(1, 9, "R10");
    rd(0, 32'h2014, "R10");

    // clearing the receive count stops receive writes
    wr(4, 32'h6000); wr(5, 5);
    reqs(0, 1, 3);
    wr(5, 0);
    reqs(0, 1, 6);
    rd(4, 32'h6008, "R11");
    rd(5, 0, "R11");

    // set and clear together: clear wins
    wr(8, 32'h3);
    rd(9, 32'h32, "R3");
    reqs(1, 0, 2);
    rd(1, 9, "R3");
    rd(8, 0, "R2");

    // mixed random traffic
    wr(8, 5);
    for (int i = 0; i < 3000; i++) begin
      tx_req = $urandom_range(0, 1); rx_req = $urandom_range(0, 1);
      rx_data = $urandom;
      reg_addr = 4'($urandom_range(0, 9));
      reg_wr = ($urandom_range(0, 7) == 0);
      if (reg_addr % 2 == 1 && reg_addr < 8) reg_wdata = $urandom_range(0, 5);
      else if (reg_addr == 8) reg_wdata = $urandom_range(0, 15);
      else reg_wdata = $urandom & 32'hFFFF_FFFC;
      cyc();
    end
    reg_wr = 0; tx_req = 0; rx_req = 0;
    cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule